// File: doc/BRIEF.md
# Asynchronous Serial Transmit Framer

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A character is handed over through a valid/ready handshake together with a line-control word. The word chooses the character length (5 to 8 bits), whether a parity bit is appended and how it is formed (odd, even, stuck at one, stuck at zero), and whether the frame ends with a short or a long stop interval. The long stop interval is one and a half bit times for the shortest character and two bit times for the others.

Bit timing comes from an external tick that pulses once per sixteenth of a bit period. The framer counts those ticks itself, so every bit lasts exactly `OVERSAMPLE` ticks and a half-bit stop extension needs no extra clock. The control word and the character are captured when the handshake completes. Later changes on those inputs have no effect on the frame under way. The block accepts a new character only while it is idle.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1, `tx_busy` is 0 and `char_ready` is 1.
- R2: A character is accepted on a clock edge where `char_valid` and `char_ready` are both 1. From the next cycle until the frame ends, `tx_busy` is 1 and `char_ready` is 0.
- R3: A frame begins with a start bit at 0 lasting 16 ticks, followed by the data bits LSB first, 16 ticks each. The count of data bits is set by `lc_wlen`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: With `lc_stop` at 0, the frame ends with a stop interval at 1 lasting 16 ticks, for every word length.
- R5: With `lc_stop` at 1 and `lc_wlen` at 00, the stop interval lasts 24 ticks.
- R6: With `lc_stop` at 1 and `lc_wlen` at 01, 10 or 11, the stop interval lasts 32 ticks.
- R7: With `lc_par_en` at 0, no parity bit is sent and the stop interval follows the last data bit directly. With `lc_par_en` at 1, a 16-tick parity bit follows the last data bit.
- R8: With parity enabled, `lc_par_force` at 0 and `lc_par_type` at 0, the parity bit makes the number of ones in the data bits plus the parity bit odd.
- R9: With parity enabled, `lc_par_force` at 0 and `lc_par_type` at 1, the parity bit makes that number even.
- R10: With parity enabled, `lc_par_force` at 1 and `lc_par_type` at 0, the parity bit is 1 whatever the data.
- R11: With parity enabled, `lc_par_force` at 1 and `lc_par_type` at 1, the parity bit is 0 whatever the data.
- R12: The character and all line-control inputs are sampled at acceptance. Changes to them while the frame is in progress do not alter that frame.
- R13: On the clock edge that consumes the last stop tick, the framer returns to idle, and a waiting character is accepted on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| char_valid | input | 1 | Character offered |
| char_ready | output | 1 | Framer idle, able to accept a character |
| char_data | input | 8 | Character; bits above the word length are ignored |
| lc_wlen | input | 2 | Word length code (00 to 11 for 5 to 8 bits) |
| lc_stop | input | 1 | Long stop interval select |
| lc_par_en | input | 1 | Parity bit enable |
| lc_par_type | input | 1 | 0 for odd, 1 for even; with forcing, 0 for mark and 1 for space |
| lc_par_force | input | 1 | Parity forced to a fixed level |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Frame in progress |

## Verification
The hardest case to reach from the ports is the 24-tick stop interval. It only appears for a 5-bit character with the long stop selected, and it ends in the middle of a bit period, so an error there is visible only if the next frame begins exactly when the stop ends. The stimulus reaches it by queueing a second character while the 5-bit frame is running, with the tick pulsing every clock. The reference model then checks the handover edge in the same cycle as the design. Held-configuration cases are covered by inverting every line-control input and the data during a frame and comparing the line tick by tick with the frame that was captured.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_START = 3'd1,
      PH_DATA  = 3'd2,
      PH_PAR   = 3'd3,
      PH_STOP  = 3'd4
   } txf_phase_e;

   typedef struct packed {
      logic [1:0] wlen;
      logic       stop_long;
      logic       par_en;
      logic       par_type;
      logic       par_force;
   } txf_lctl_t;

endpackage

// File: rtl/txf_capture.sv
module txf_capture
   import uart_txf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] data_in,
   input  txf_lctl_t         lctl_in,
   output logic [DATA_W-1:0] data_q,
   output txf_lctl_t         lctl_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         lctl_q <= '0;
      end else if (load) begin
         data_q <= data_in;
         lctl_q <= lctl_in;
      end
   end

endmodule

// File: rtl/txf_parity.sv
module txf_parity #(
   parameter int DATA_W   = 8,
   parameter int WLEN_W   = 2,
   localparam int MIN_BITS = DATA_W - (1 << WLEN_W) + 1
) (
   input  logic [DATA_W-1:0] data,
   input  logic [WLEN_W-1:0] wlen,
   input  logic              par_type,
   input  logic              par_force,
   output logic              par_bit
);

   logic [DATA_W-1:0] mask;
   logic              ones_odd;

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
      if (gi < MIN_BITS) begin : g_always
         assign mask[gi] = 1'b1;
      end else begin : g_sel
         assign mask[gi] = (int'(wlen) >= (gi - MIN_BITS + 1));
      end
   end

   assign ones_odd = ^(data & mask);

   always_comb begin
      if (par_force) par_bit = ~par_type;
      else if (par_type) par_bit = ones_odd;
      else par_bit = ~ones_odd;
   end

endmodule

// File: rtl/txf_sequencer.sv
module txf_sequencer
   import uart_txf_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int DATA_W     = 8,
   localparam int CNT_W  = $clog2(2 * OVERSAMPLE),
   localparam int IDX_W  = $clog2(DATA_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic [IDX_W-1:0] last_idx,
   input  logic             par_en,
   input  logic [CNT_W-1:0] stop_last,
   output txf_phase_e       phase,
   output logic [IDX_W-1:0] bit_idx,
   output logic             busy
);

   localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVERSAMPLE - 1);

   logic [CNT_W-1:0] cnt;
   logic             bit_end;
   logic             stop_end;

   assign bit_end  = tick && (cnt == BIT_LAST);
   assign stop_end = tick && (cnt == stop_last);
   assign busy     = (phase != PH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               cnt     <= '0;
               bit_idx <= '0;
               if (start) phase <= PH_START;
            end
            PH_START: begin
               if (bit_end) begin
                  cnt   <= '0;
                  phase <= PH_DATA;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_DATA: begin
               if (bit_end) begin
                  cnt <= '0;
                  if (bit_idx == last_idx) begin
                     phase <= par_en ? PH_PAR : PH_STOP;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                  end
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_PAR: begin
               if (bit_end) begin
                  cnt   <= '0;
                  phase <= PH_STOP;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_STOP: begin
               if (stop_end) begin
                  cnt   <= '0;
                  phase <= PH_IDLE;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   AST_DATA_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA) |-> (bit_idx <= last_idx)); // R3
   AST_PAR_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PAR) |-> par_en); // R7
   AST_STOP_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STOP) |-> (cnt <= stop_last)); // R5
   AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STOP && stop_end) |=> (phase == PH_IDLE)); // R13

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_txf_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int DATA_W     = 8,
   parameter int WLEN_W     = 2,
   parameter bit OUT_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              char_valid,
   output logic              char_ready,
   input  logic [DATA_W-1:0] char_data,
   input  logic [WLEN_W-1:0] lc_wlen,
   input  logic              lc_stop,
   input  logic              lc_par_en,
   input  logic              lc_par_type,
   input  logic              lc_par_force,
   output logic              tx_line,
   output logic              tx_busy
);

   localparam int MIN_BITS = DATA_W - (1 << WLEN_W) + 1;
   localparam int CNT_W    = $clog2(2 * OVERSAMPLE);
   localparam int IDX_W    = $clog2(DATA_W);

   if (OVERSAMPLE < 2 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("OVERSAMPLE must be even and at least 2");
   end
   if (WLEN_W != 2) begin : g_bad_wlen
      $error("WLEN_W must be 2 for the lc_wlen field");
   end
   if (MIN_BITS < 1) begin : g_bad_width
      $error("DATA_W too small for the word length field");
   end

   txf_lctl_t         lctl_in, lctl_q;
   logic [DATA_W-1:0] data_q;
   logic              accept;
   logic              par_bit;
   logic [IDX_W-1:0]  last_idx;
   logic [CNT_W-1:0]  stop_last;
   logic [IDX_W-1:0]  bit_idx;
   txf_phase_e        phase;
   logic              busy;
   logic              line_d;

   assign lctl_in.wlen      = lc_wlen;
   assign lctl_in.stop_long = lc_stop;
   assign lctl_in.par_en    = lc_par_en;
   assign lctl_in.par_type  = lc_par_type;
   assign lctl_in.par_force = lc_par_force;

   assign char_ready = ~busy;
   assign tx_busy    = busy;
   assign accept     = char_valid & char_ready;

   txf_capture #(.DATA_W(DATA_W)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .data_in (char_data),
      .lctl_in (lctl_in),
      .data_q  (data_q),
      .lctl_q  (lctl_q)
   );

   txf_parity #(.DATA_W(DATA_W), .WLEN_W(WLEN_W)) u_parity (
      .data      (data_q),
      .wlen      (lctl_q.wlen),
      .par_type  (lctl_q.par_type),
      .par_force (lctl_q.par_force),
      .par_bit   (par_bit)
   );

   assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(lctl_q.wlen);

   always_comb begin
      if (!lctl_q.stop_long) stop_last = CNT_W'(OVERSAMPLE - 1);
      else if (lctl_q.wlen == '0) stop_last = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
      else stop_last = CNT_W'(2 * OVERSAMPLE - 1);
   end

   txf_sequencer #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick16),
      .start     (accept),
      .last_idx  (last_idx),
      .par_en    (lctl_q.par_en),
      .stop_last (stop_last),
      .phase     (phase),
      .bit_idx   (bit_idx),
      .busy      (busy)
   );

   always_comb begin
      case (phase)
         PH_START: line_d = 1'b0;
         PH_DATA:  line_d = data_q[bit_idx];
         PH_PAR:   line_d = par_bit;
         default:  line_d = 1'b1;
      endcase
   end

   if (OUT_REG) begin : g_line_reg
      always_ff @(posedge clk) begin
         if (!rst_n) tx_line <= 1'b1;
         else tx_line <= line_d;
      end
   end else begin : g_line_comb
      assign tx_line = line_d;

      AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         !busy |-> tx_line); // R1
      AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
         (char_valid && char_ready) |=> (tx_busy && !tx_line)); // R2
      AST_PARITY_SUM: assert property (@(posedge clk) disable iff (!rst_n)
         (phase == PH_PAR && !lctl_q.par_force) |->
         ((((($countones(data_q[MIN_BITS-1:0]) + $countones(data_q[DATA_W-1:MIN_BITS] &
            ((DATA_W-MIN_BITS)'(1) << lctl_q.wlen) - 1'b1)) + (tx_line ? 1 : 0)) % 2) == 1)
          != lctl_q.par_type)); // R8
      AST_PARITY_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
         (phase == PH_PAR && lctl_q.par_force) |-> (tx_line != lctl_q.par_type)); // R10
   end

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(lctl_q) && $stable(data_q))); // R12

endmodule

// File: tb/uart_tx_framer_bench.sv
`timescale 1ns/1ps
module uart_tx_framer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       char_valid = 1'b0;
   logic       char_ready;
   logic [7:0] char_data = '0;
   logic [1:0] lc_wlen = '0;
   logic       lc_stop = 1'b0;
   logic       lc_par_en = 1'b0;
   logic       lc_par_type = 1'b0;
   logic       lc_par_force = 1'b0;
   logic       tx_line;
   logic       tx_busy;

   int    checks = 0;
   int    failures = 0;
   int    tick_period = 3;
   int    tick_cnt = 0;
   bit    model_on = 1'b0;
   string cur_tag = "R1";
   logic  exp_q[$];

   always #10 clk = ~clk;

   uart_tx_framer u_uart_tx_framer (
      .clk(clk), .rst_n(rst_n), .tick16(tick16),
      .char_valid(char_valid), .char_ready(char_ready), .char_data(char_data),
      .lc_wlen(lc_wlen), .lc_stop(lc_stop), .lc_par_en(lc_par_en),
      .lc_par_type(lc_par_type), .lc_par_force(lc_par_force),
      .tx_line(tx_line), .tx_busy(tx_busy)
   );

   // Tick generator, driven away from the active edge
   always @(negedge clk) begin
      if (tick_cnt >= tick_period - 1) begin
         tick_cnt = 0;
         tick16 = 1'b1;
      end else begin
         tick_cnt = tick_cnt + 1;
         tick16 = 1'b0;
      end
   end

   task automatic push_bit(input logic v, input int n);
      for (int k = 0; k < n; k++) exp_q.push_back(v);
   endtask

   task automatic build_frame();
      int   nb;
      logic ones;
      logic pb;
      nb = 5 + int'(lc_wlen);
      ones = 1'b0;
      push_bit(1'b0, 16);
      for (int i = 0; i < nb; i++) begin
         push_bit(char_data[i], 16);
         ones = ones ^ char_data[i];
      end
      if (lc_par_en) begin
         if (lc_par_force) pb = ~lc_par_type;
         else if (lc_par_type) pb = ones;
         else pb = ~ones;
         push_bit(pb, 16);
      end
      if (!lc_stop) push_bit(1'b1, 16);
      else if (nb == 5) push_bit(1'b1, 24);
      else push_bit(1'b1, 32);
   endtask

   // Reference model: one queue entry per tick slot of the frame
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_q.delete();
      end else if (exp_q.size() != 0) begin
         if (tick16) void'(exp_q.pop_front());
      end else if (char_valid) begin
         build_frame();
      end
   end

   task automatic check1(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (model_on && rst_n) begin
         logic el, eb;
         eb = (exp_q.size() != 0);
         el = eb ? exp_q[0] : 1'b1;
         check1(cur_tag, "tx_line", tx_line, el);
         check1(cur_tag, "tx_busy", tx_busy, eb);
         check1(cur_tag, "char_ready", char_ready, ~eb);
      end
   end

   task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic st,
                       input logic pe, input logic pt, input logic pf, input string tag);
      @(negedge clk);
      cur_tag = tag;
      char_data = d; lc_wlen = wl; lc_stop = st;
      lc_par_en = pe; lc_par_type = pt; lc_par_force = pf;
      char_valid = 1'b1;
      while (!char_ready) @(negedge clk);
      @(negedge clk);
      char_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (tx_busy) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check1("R1", "reset tx_line", tx_line, 1'b1);
      check1("R1", "reset tx_busy", tx_busy, 1'b0);
      check1("R1", "reset char_ready", char_ready, 1'b1);
      rst_n = 1'b1;
      model_on = 1'b1;
      repeat (5) @(negedge clk);

      // R3 R4 R7: every word length, short stop, no parity
      send(8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R3/R4/R7 wlen8"); wait_idle();
      send(8'hF3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R3/R4 wlen5");    wait_idle();
      send(8'h5A, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R3/R4 wlen6");    wait_idle();
      send(8'hC9, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "R3/R4 wlen7");    wait_idle();
      // R5: 1.5 stop interval
      send(8'h15, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R5 wlen5 long stop"); wait_idle();
      // R6: two stop bits
      send(8'h2B, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R6 wlen6 long stop"); wait_idle();
      send(8'h7E, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, "R6 wlen7 long stop"); wait_idle();
      send(8'h81, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R6 wlen8 long stop"); wait_idle();
      // R8: odd parity, data with odd and even ones
      send(8'h37, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, "R8 odd"); wait_idle();
      send(8'h33, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, "R8 odd"); wait_idle();
      send(8'hE3, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R8 odd wlen5 upper ignored"); wait_idle();
      // R9: even parity
      send(8'h37, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, "R9 even"); wait_idle();
      send(8'hC1, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, "R9 even wlen7"); wait_idle();
      // R10 R11: forced parity
      send(8'h00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, "R10 mark"); wait_idle();
      send(8'hFF, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, "R10 mark"); wait_idle();
      send(8'hFF, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, "R11 space"); wait_idle();
      send(8'h01, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, "R11 space"); wait_idle();
      // R12: inputs change during the frame
      send(8'h4D, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, "R12 held config");
      @(negedge clk);
      char_data = ~char_data; lc_wlen = ~lc_wlen; lc_stop = ~lc_stop;
      lc_par_en = ~lc_par_en; lc_par_type = ~lc_par_type; lc_par_force = ~lc_par_force;
      wait_idle();
      // R13: back-to-back frames, tick every clock, half-bit stop handover
      tick_period = 1;
      send(8'h0B, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, "R13 back-to-back");
      send(8'h96, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R13 back-to-back");
      send(8'h12, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, "R13 back-to-back");
      wait_idle();
      tick_period = 3;
      repeat (4) @(negedge clk);
      cur_tag = "R1 idle";
      repeat (4) @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule